// File: doc/BRIEF.md
# Link Sampling-Delay Scan Checker

This block searches for a working receive timing on a bundle of eight parallel 8-bit front-end links, 64 data lines in all. Each line is delayed by its own local setting plus one global setting that is shared by every line. Both settings run from 0 to 15 elements. Inside the block each element is modelled as one clock cycle of delay. While the scan runs, the sending side transmits a fixed 32-word test pattern on every link. Each frame start strobe marks the first word of a frame. The block compares every delayed bit with the expected pattern bit for that cycle and counts the mismatches.

A scan begins on a start pulse. It visits all 256 grid points with the global setting as the outer loop and the local setting as the inner loop. Each point is judged over a fixed number of whole frames. The total mismatch count for each point is stored in a table that can be read back. Each global row is then examined. A row is accepted only if every one of the 64 lines has at least one error-free local setting in that row. The lowest accepted row wins. In that row, each line is given the midpoint of its first and last error-free local setting. When the scan finishes, these chosen settings stay on the delay outputs.

Top module: `lsc_scan_top`

## Requirements
- R1: While reset is high and in the cycle after reset, scan_busy and scan_done are low and every delay output is zero.
- R2: Expected pattern word k, for k from 0 to 30, is the low 8 bits of (k*73) XOR 0x96. Word 31 is the bitwise NOT of the XOR of words 0 to 30. The word index is 0 in a cycle where frame_start is high and advances by one on each following clock. All links are compared with the same word, and link n occupies rx_data[8n+7:8n].
- R3: The sample compared for line i is rx_data[i] taken (local_i + global) cycles earlier, where local_i = dly_local[4i+3:4i] and global = dly_global.
- R4: A scan_start while the block is idle or done sets scan_busy in the next cycle. During a scan, all 64 local fields are equal, and the point {global,local} only ever advances by one, from {0,0} to {15,15}.
- R5: Each point is judged over FRAMES whole frames, starting at a frame_start. The total number of mismatching bits over all lines is readable at address global*16+local.
- R6: A point's error total saturates at 2^CNT_W-1 instead of wrapping.
- R7: A global row is accepted only when every line has zero errors at one or more local settings in that row. The lowest accepted row is chosen. Address 320 reads {found in bit 4, chosen global in bits 3:0}, and is zero when no row is accepted.
- R8: For each line, the chosen local setting is floor((first+last)/2), where first and last are the lowest and highest error-free local settings in the chosen row. Address 256+i reads last in bits 7:4 and first in bits 3:0.
- R9: Once done, dly_global holds the chosen global setting and each dly_local field holds the line's chosen setting, or all zeros if no row was accepted. These values stay stable until the next start.
- R10: scan_done stays high after completion until the next scan_start, and it is never high together with scan_busy.
- R11: rd_data shows the word at rd_addr one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Starts a full grid scan |
| frame_start | input | 1 | High in the cycle that carries pattern word 0 |
| rx_data | input | 64 | Received lines, eight links of 8 bits |
| dly_local | output | 256 | Per-line local delay, 4 bits per line |
| dly_global | output | 4 | Shared global delay |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Scan finished, results valid |
| rd_addr | input | 9 | Result read address |
| rd_data | output | CNT_W | Result read data |

## Verification
Three input patterns are used. In the first, every line is skewed by a random amount inside a 16-cycle spread, so one row is accepted and each line's chosen local setting depends on its own skew. This separates correct per-line window tracking from a setting shared across lines. In the second, almost all lines have zero skew and two lines are set to the edge values 9 and 15, which forces row 0 and checks the window ends at the local limits. In the third, the pattern is inverted on every line, so no point is error-free: no row can be accepted, the outputs fall back to zero, and the error totals push against the saturation limit.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_ACTIVE, ST_CLOSE, ST_ROWEND, ST_FINAL, ST_DONE
  } scan_st_e;

  localparam int PAT_MUL = 73;
  localparam int PAT_XOR = 'h96;
endpackage

// File: rtl/lsc_pattern_rom.sv
module lsc_pattern_rom #(
  parameter int PAT_LEN = 32,
  parameter int WORD_W  = 8,
  localparam int IDX_W  = $clog2(PAT_LEN)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  function automatic logic [WORD_W-1:0] pat_fn(input int k);
    logic [31:0] v;
    logic [WORD_W-1:0] acc;
    if (k < PAT_LEN - 1) begin
      v = 32'(k * lsc_pkg::PAT_MUL) ^ 32'(lsc_pkg::PAT_XOR);
      return v[WORD_W-1:0];
    end
    acc = '1;
    for (int j = 0; j < PAT_LEN - 1; j++) begin
      v = 32'(j * lsc_pkg::PAT_MUL) ^ 32'(lsc_pkg::PAT_XOR);
      acc = acc ^ v[WORD_W-1:0];
    end
    return acc;
  endfunction

  logic [WORD_W-1:0] rom [PAT_LEN];
  for (genvar k = 0; k < PAT_LEN; k++) begin : g_rom
    assign rom[k] = pat_fn(k);
  end

  assign word = rom[idx];
endmodule

// File: rtl/lsc_tap_delay.sv
module lsc_tap_delay #(
  parameter int LINES = 64,
  parameter int DLY_W = 4,
  localparam int MAX_DLY = 2 * ((1 << DLY_W) - 1)
) (
  input  logic                   clk,
  input  logic [LINES-1:0]       din,
  input  logic [LINES*DLY_W-1:0] loc,
  input  logic [DLY_W-1:0]       glb,
  output logic [LINES-1:0]       dout
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [MAX_DLY-1:0] sr;
    logic [DLY_W:0]     tap;
    logic [DLY_W:0]     tap_m1;

    always_ff @(posedge clk) sr <= {sr[MAX_DLY-2:0], din[i]};

    assign tap    = {1'b0, loc[i*DLY_W +: DLY_W]} + {1'b0, glb};
    assign tap_m1 = tap - 1'b1;
    assign dout[i] = (tap == '0) ? din[i] : sr[tap_m1];
  end
endmodule

// File: rtl/lsc_err_accum.sv
module lsc_err_accum #(
  parameter int LINES = 64,
  parameter int CNT_W = 16,
  localparam int PC_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic [LINES-1:0] err,
  output logic [CNT_W-1:0] total,
  output logic [LINES-1:0] bad
);
  logic [PC_W-1:0]  pc;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;

  always_comb begin
    pc = '0;
    for (int i = 0; i < LINES; i++) pc = pc + PC_W'(err[i]);
  end

  assign base = clr ? '0 : total;
  assign sum  = {1'b0, base} + (CNT_W+1)'(pc);

  always_ff @(posedge clk) begin
    if (en) begin
      total <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      bad   <= (clr ? '0 : bad) | err;
    end else if (clr) begin
      total <= '0;
      bad   <= '0;
    end
  end
endmodule

// File: rtl/lsc_scan_top.sv
module lsc_scan_top #(
  parameter int N_LINK  = 8,
  parameter int LINK_W  = 8,
  parameter int DLY_W   = 4,
  parameter int PAT_LEN = 32,
  parameter int FRAMES  = 100,
  parameter int CNT_W   = 16,
  localparam int LINES  = N_LINK * LINK_W,
  localparam int N_SET  = 1 << DLY_W,
  localparam int PTS    = N_SET * N_SET,
  localparam int ADDR_W = $clog2(PTS + LINES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scan_start,
  input  logic                   frame_start,
  input  logic [LINES-1:0]       rx_data,
  output logic [LINES*DLY_W-1:0] dly_local,
  output logic [DLY_W-1:0]       dly_global,
  output logic                   scan_busy,
  output logic                   scan_done,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [CNT_W-1:0]       rd_data
);
  import lsc_pkg::*;

  localparam int IDX_W  = $clog2(PAT_LEN);
  localparam int FCNT_W = $clog2(FRAMES + 1);
  localparam int PT_W   = 2 * DLY_W;
  localparam logic [DLY_W-1:0] SET_MAX = DLY_W'(N_SET - 1);

  scan_st_e st;
  logic [DLY_W-1:0]  cur_l, glb_q, g_sel;
  logic [FCNT_W-1:0] fcnt;
  logic              found;
  logic [LINES-1:0]  vld;
  logic [DLY_W-1:0]  first_r [LINES];
  logic [DLY_W-1:0]  last_r  [LINES];
  logic [DLY_W-1:0]  first_s [LINES];
  logic [DLY_W-1:0]  last_s  [LINES];
  logic [DLY_W-1:0]  loc_q   [LINES];
  logic [DLY_W-1:0]  centre  [LINES];

  // Pattern index: word 0 on the strobe cycle, then one step per clock
  logic [IDX_W-1:0]  idx_q, cur_idx;
  logic [LINK_W-1:0] exp_word;
  logic [LINES-1:0]  exp_line, dly_data, err;

  assign cur_idx = frame_start ? '0 : idx_q;
  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= (cur_idx == IDX_W'(PAT_LEN - 1)) ? '0 : cur_idx + 1'b1;
  end

  lsc_pattern_rom #(.PAT_LEN(PAT_LEN), .WORD_W(LINK_W)) u_rom (
    .idx(cur_idx), .word(exp_word)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_lane
    assign exp_line[i] = exp_word[i % LINK_W];
    assign dly_local[i*DLY_W +: DLY_W] = loc_q[i];
    logic [DLY_W:0] csum;
    assign csum      = {1'b0, first_s[i]} + {1'b0, last_s[i]};
    assign centre[i] = csum[DLY_W:1];
  end

  lsc_tap_delay #(.LINES(LINES), .DLY_W(DLY_W)) u_dly (
    .clk(clk), .din(rx_data), .loc(dly_local), .glb(glb_q), .dout(dly_data)
  );

  assign err = dly_data ^ exp_line;

  logic             acc_en, acc_clr;
  logic [CNT_W-1:0] total;
  logic [LINES-1:0] bad;

  assign acc_clr = (st == ST_ARM);
  assign acc_en  = (st == ST_ARM && frame_start) ||
                   (st == ST_ACTIVE && !(frame_start && fcnt == FCNT_W'(FRAMES)));

  lsc_err_accum #(.LINES(LINES), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .clr(acc_clr), .en(acc_en), .err(err), .total(total), .bad(bad)
  );

  // Scan controller
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cur_l <= '0;
      glb_q <= '0;
      g_sel <= '0;
      fcnt  <= '0;
      found <= 1'b0;
      vld   <= '0;
      for (int i = 0; i < LINES; i++) begin
        loc_q[i] <= '0; first_r[i] <= '0; last_r[i] <= '0;
        first_s[i] <= '0; last_s[i] <= '0;
      end
    end else begin
      case (st)
        ST_IDLE, ST_DONE: if (scan_start) begin
          st    <= ST_ARM;
          cur_l <= '0;
          glb_q <= '0;
          g_sel <= '0;
          found <= 1'b0;
          vld   <= '0;
          for (int i = 0; i < LINES; i++) begin
            loc_q[i] <= '0; first_s[i] <= '0; last_s[i] <= '0;
          end
        end
        ST_ARM: if (frame_start) begin
          st   <= ST_ACTIVE;
          fcnt <= FCNT_W'(1);
        end
        ST_ACTIVE: if (frame_start) begin
          if (fcnt == FCNT_W'(FRAMES)) st <= ST_CLOSE;
          else                         fcnt <= fcnt + 1'b1;
        end
        ST_CLOSE: begin
          for (int i = 0; i < LINES; i++) begin
            if (!bad[i]) begin
              if (!vld[i]) first_r[i] <= cur_l;
              last_r[i] <= cur_l;
              vld[i]    <= 1'b1;
            end
          end
          if (cur_l == SET_MAX) st <= ST_ROWEND;
          else begin
            cur_l <= cur_l + 1'b1;
            for (int i = 0; i < LINES; i++) loc_q[i] <= cur_l + 1'b1;
            st <= ST_ARM;
          end
        end
        ST_ROWEND: begin
          if (&vld && !found) begin
            found <= 1'b1;
            g_sel <= glb_q;
            for (int i = 0; i < LINES; i++) begin
              first_s[i] <= first_r[i];
              last_s[i]  <= last_r[i];
            end
          end
          vld <= '0;
          if (glb_q == SET_MAX) st <= ST_FINAL;
          else begin
            glb_q <= glb_q + 1'b1;
            cur_l <= '0;
            for (int i = 0; i < LINES; i++) loc_q[i] <= '0;
            st <= ST_ARM;
          end
        end
        ST_FINAL: begin
          glb_q <= found ? g_sel : '0;
          for (int i = 0; i < LINES; i++) loc_q[i] <= found ? centre[i] : '0;
          st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign dly_global = glb_q;
  assign scan_busy  = (st == ST_ARM) || (st == ST_ACTIVE) ||
                      (st == ST_CLOSE) || (st == ST_ROWEND);
  assign scan_done  = (st == ST_DONE);

  // Error table, one word per grid point, block-RAM shaped
  logic [CNT_W-1:0] err_mem [PTS];
  logic [CNT_W-1:0] mem_q, aux, aux_q;
  logic             sel_q;

  always_ff @(posedge clk) begin
    if (st == ST_CLOSE) err_mem[{glb_q, cur_l}] <= total;
  end

  always_ff @(posedge clk) mem_q <= err_mem[rd_addr[PT_W-1:0]];

  always_comb begin
    aux = CNT_W'({found, g_sel});
    for (int i = 0; i < LINES; i++)
      if (rd_addr == ADDR_W'(PTS + i)) aux = CNT_W'({last_s[i], first_s[i]});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_q <= '0;
      sel_q <= 1'b0;
    end else begin
      aux_q <= aux;
      sel_q <= (rd_addr >= ADDR_W'(PTS));
    end
  end

  assign rd_data = sel_q ? aux_q : mem_q;
endmodule

// File: rtl/lsc_scan_chk.sv
module lsc_scan_chk #(
  parameter int LINES = 64,
  parameter int DLY_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scan_start,
  input logic                   scan_busy,
  input logic                   scan_done,
  input logic [LINES*DLY_W-1:0] dly_local,
  input logic [DLY_W-1:0]       dly_global
);
  logic [2*DLY_W-1:0] pt;
  assign pt = {dly_global, dly_local[DLY_W-1:0]};

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!scan_busy && !scan_done && dly_global == '0 && dly_local == '0)); // R1

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (scan_start && scan_done) |=> scan_busy); // R4

  AST_UNIFORM_LOCAL: assert property (@(posedge clk) disable iff (rst)
    scan_busy |-> (dly_local == {LINES{dly_local[DLY_W-1:0]}})); // R4

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (scan_busy && $past(scan_busy) && pt != $past(pt)) |->
    (pt == $past(pt) + 1'b1)); // R4

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(scan_busy && scan_done)); // R10

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (scan_done && !scan_start) |=>
    (scan_done && $stable(dly_global) && $stable(dly_local))); // R9
endmodule

bind lsc_scan_top lsc_scan_chk #(.LINES(LINES), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst(rst), .scan_start(scan_start), .scan_busy(scan_busy),
  .scan_done(scan_done), .dly_local(dly_local), .dly_global(dly_global)
);

// File: tb/tb_lsc_scan_top.sv
module tb_lsc_scan_top;
  localparam int N_LINK = 8, LINK_W = 8, DLY_W = 4, PAT_LEN = 32;
  localparam int FRAMES = 4, CNT_W = 12;
  localparam int LINES = 64, N_SET = 16, PTS = 256, ADDR_W = 9;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic                   clk = 0, rst = 1, scan_start = 0, frame_start = 0;
  logic [LINES-1:0]       rx_data = '0;
  logic [LINES*DLY_W-1:0] dly_local;
  logic [DLY_W-1:0]       dly_global;
  logic                   scan_busy, scan_done;
  logic [ADDR_W-1:0]      rd_addr = '0;
  logic [CNT_W-1:0]       rd_data;

  lsc_scan_top #(.N_LINK(N_LINK), .LINK_W(LINK_W), .DLY_W(DLY_W), .PAT_LEN(PAT_LEN),
                 .FRAMES(FRAMES), .CNT_W(CNT_W)) dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int skew [LINES];
  bit inv = 0;
  int mism [LINES][31];
  bit done_flag = 0;

  function automatic int pat_word(int k);
    int acc;
    if (k < 31) return ((k * 73) ^ 'h96) & 255;
    acc = 255;
    for (int j = 0; j < 31; j++) acc ^= ((j * 73) ^ 'h96) & 255;
    return acc;
  endfunction

  function automatic int pat_bit(int k, int b);
    return (pat_word(k) >> b) & 1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Link model: line i runs skew[i] words ahead of the frame strobe
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      frame_start = (t % 32 == 0);
      for (int i = 0; i < LINES; i++)
        rx_data[i] = pat_bit(((t % 32) + skew[i]) % 32, i % 8) ^ inv;
      t++;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic build_model();
    for (int i = 0; i < LINES; i++)
      for (int d = 0; d < 31; d++) begin
        int m = 0;
        for (int k = 0; k < 32; k++) begin
          int rcv = pat_bit((k - d + skew[i] + 64) % 32, i % 8) ^ int'(inv);
          if (rcv != pat_bit(k, i % 8)) m++;
        end
        mism[i][d] = m;
      end
  endtask

  task automatic rd(int a, output int v);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic run_scan(string tag);
    int eg, efound, v;
    int ef [LINES];
    int el [LINES];
    build_model();
    efound = 0; eg = 0;
    for (int g = 0; g < N_SET && !efound; g++) begin
      bit all_ok = 1;
      for (int i = 0; i < LINES; i++) begin
        bit any = 0;
        for (int l = 0; l < N_SET; l++) if (mism[i][g+l] == 0) any = 1;
        if (!any) all_ok = 0;
      end
      if (all_ok) begin efound = 1; eg = g; end
    end
    for (int i = 0; i < LINES; i++) begin
      ef[i] = 0; el[i] = 0;
      if (efound) begin
        ef[i] = -1;
        for (int l = 0; l < N_SET; l++)
          if (mism[i][eg+l] == 0) begin
            if (ef[i] < 0) ef[i] = l;
            el[i] = l;
          end
      end
    end

    @(negedge clk); scan_start = 1;
    @(negedge clk); scan_start = 0;
    chk(scan_busy == 1, "R4", {tag, " busy after start"}, int'(scan_busy), 1);
    chk(scan_done == 0, "R10", {tag, " done cleared by start"}, int'(scan_done), 0);
    while (!scan_done) @(negedge clk);

    chk(int'(dly_global) == eg, "R9", {tag, " chosen global"}, int'(dly_global), eg);
    for (int i = 0; i < LINES; i++) begin
      int exp_c = (ef[i] + el[i]) / 2;
      chk(int'(dly_local[i*4 +: 4]) == exp_c, "R8", {tag, " chosen local (R3 delay)"},
          int'(dly_local[i*4 +: 4]), exp_c);
    end
    rd(320, v);
    chk(v == (efound ? (16 | eg) : 0), "R7", {tag, " status word"}, v, efound ? (16 | eg) : 0);
    for (int i = 0; i < LINES; i++) begin
      rd(PTS + i, v);
      chk(v == (el[i] * 16 + ef[i]), "R8", {tag, " window word"}, v, el[i] * 16 + ef[i]);
    end
    for (int p = 0; p < PTS; p++) begin
      int s = 0, e;
      for (int i = 0; i < LINES; i++) s += mism[i][(p / 16) + (p % 16)];
      e = s * FRAMES;
      if (e > CMAX) e = CMAX;
      rd(p, v);
      chk(v == e, "R5", {tag, " point total (R2 pattern, R6 saturation, R11 read)"}, v, e);
    end
    repeat (5) @(negedge clk);
    chk(scan_done == 1 && scan_busy == 0, "R10", {tag, " done holds"},
        int'({scan_busy, scan_done}), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < LINES; i++) skew[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(scan_busy == 0, "R1", "busy after reset", int'(scan_busy), 0);
    chk(scan_done == 0, "R1", "done after reset", int'(scan_done), 0);
    chk(dly_global == 0, "R1", "global after reset", int'(dly_global), 0);
    chk(dly_local == '0, "R1", "locals after reset", int'(dly_local != '0), 0);
    repeat (60) @(negedge clk);

    begin
      int base = int'($urandom_range(0, 10));
      for (int i = 0; i < LINES; i++) skew[i] = base + int'($urandom_range(0, 15));
    end
    repeat (40) @(negedge clk);
    run_scan("random skew");

    for (int i = 0; i < LINES; i++) skew[i] = 0;
    skew[0] = 9; skew[63] = 15;
    repeat (40) @(negedge clk);
    run_scan("edge skew");

    inv = 1;
    repeat (40) @(negedge clk);
    run_scan("inverted");

    finish_run();
  end
endmodule